// File: doc/BRIEF.md
# Integer Logic, Shift and Add Unit

A purely combinational execution unit for a 32-bit integer datapath. Each evaluation takes two operands, a 5-bit shift distance and a 4-bit operation code, and returns a result word together with a write qualifier for the destination register and an overflow exception flag. It covers bitwise logic (AND, OR, XOR, NOR), three shifts (logical left, logical right, arithmetic right) and addition and subtraction, the latter two each in a trapping and a wrapping flavour.

Subtraction is formed by adding the two's complement of the second operand. Only the trapping flavours look at signed overflow; when it occurs the exception flag rises and the write qualifier drops, so the destination keeps its old value. The wrapping flavours always write. The shifter shifts the first operand (`opa_i`) by `shamt_i`; `opb_i` is unused by shifts.

Top module: `alu_lsa`

Operation codes (`op_i`): 0 AND, 1 OR, 2 XOR, 3 NOR, 4 shift left logical, 5 shift right logical, 6 shift right arithmetic, 8 add trapping, 9 add wrapping, 10 subtract trapping, 11 subtract wrapping. Codes 7 and 12 to 15 are undefined.

## Requirements
- R1: Codes 0, 1 and 2 return the bitwise AND, OR and XOR of `opa_i` and `opb_i`, with the write qualifier high and no exception.
- R2: Code 3 returns the bitwise inverse of (`opa_i` OR `opb_i`); with `opb_i` zero this is the inverse of `opa_i`.
- R3: Code 4 shifts `opa_i` left by `shamt_i` (0 to 31) and fills vacated low bits with 0.
- R4: Code 5 shifts `opa_i` right by `shamt_i` and fills vacated high bits with 0.
- R5: Code 6 shifts `opa_i` right by `shamt_i` and fills vacated high bits with copies of `opa_i[31]`.
- R6: A shift distance of 0 returns `opa_i` unchanged for codes 4, 5 and 6.
- R7: Codes 8 and 9 return `opa_i + opb_i` modulo 2^32; codes 10 and 11 return `opa_i + ~opb_i + 1` modulo 2^32, also when the exception is raised.
- R8: For code 8 the exception is raised exactly when both operands have the same sign bit and the result sign bit differs from it.
- R9: For code 10 the exception is raised exactly when the operand sign bits differ and the result sign bit differs from that of `opa_i`.
- R10: Codes 9 and 11, and every non-arithmetic code, never raise the exception.
- R11: The write qualifier is low whenever the exception is high, and high for every other defined code.
- R12: Undefined codes (7, 12 to 15) return zero with the write qualifier and exception both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand; the value shifted by shift codes |
| opb_i | input | 32 | Second operand |
| shamt_i | input | 5 | Shift distance |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write qualifier |
| ovf_exc_o | output | 1 | Signed overflow exception |

## Verification
The two functions that meet in one evaluation are the wrapped arithmetic result and the overflow trap that cancels its write. The bench provokes them with directed operand pairs at the signed limits (maximum positive plus one, minimum negative minus one, and their same-sign and mixed-sign neighbours) and with random operands whose sign bits are forced, and for each it judges result, exception and write qualifier together against a model built on 33-bit signed arithmetic, checking that the wrapped sum still appears while the write is withheld.

// File: rtl/alu_lsa_pkg.sv
package alu_lsa_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned SHW  = $clog2(XLEN);

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_NOR  = 4'd3,
    OP_SLL  = 4'd4,
    OP_SRL  = 4'd5,
    OP_SRA  = 4'd6,
    OP_ADDT = 4'd8,
    OP_ADDW = 4'd9,
    OP_SUBT = 4'd10,
    OP_SUBW = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;
endpackage

// File: rtl/alu_lsa_logic.sv
module alu_lsa_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   fn_i,
  output logic [W-1:0] y_o
);
  import alu_lsa_pkg::*;

  always_comb begin
    unique case (logic_fn_e'(fn_i))
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_lsa_shift.sv
module alu_lsa_shift #(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  y_o
);
  logic [W-1:0] stage [SW+1];
  logic [W-1:0] a_rev;
  logic [W-1:0] y_rev;
  logic         fill;

  // left shift = reverse, shift right, reverse
  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign a_rev[i] = a_i[W-1-i];
  end

  assign fill     = arith_i & ~left_i & a_i[W-1];
  assign stage[0] = left_i ? a_rev : a_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
  end

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign y_rev[i] = stage[SW][W-1-i];
  end

  assign y_o = left_i ? y_rev : stage[SW];
endmodule

// File: rtl/alu_lsa_addsub.sv
module alu_lsa_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   raw;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign raw   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o = raw[W-1:0];
  // same sign in, different sign out
  assign ovf_o = (a_i[W-1] == b_eff[W-1]) & (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_lsa.sv
module alu_lsa
  import alu_lsa_pkg::*;
#(
  parameter int unsigned W = XLEN,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  input  logic [SW-1:0] shamt_i,
  input  logic [3:0]    op_i,
  output logic [W-1:0]  result_o,
  output logic          wr_en_o,
  output logic          ovf_exc_o
);
  logic [W-1:0] logic_y, shift_y, arith_y;
  logic         arith_ovf;
  logic         is_logic, is_shift, is_arith, trap_en;

  assign is_logic = (op_i[3:2] == 2'b00);
  assign is_shift = (op_i[3:2] == 2'b01) & (op_i[1:0] != 2'b11);
  assign is_arith = (op_i[3:2] == 2'b10);
  assign trap_en  = is_arith & ~op_i[0];

  alu_lsa_logic #(.W(W)) u_logic (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .fn_i (op_i[1:0]),
    .y_o  (logic_y)
  );

  alu_lsa_shift #(.W(W)) u_shift (
    .a_i     (opa_i),
    .amt_i   (shamt_i),
    .left_i  (op_i[1:0] == 2'b00),
    .arith_i (op_i[1]),
    .y_o     (shift_y)
  );

  alu_lsa_addsub #(.W(W)) u_addsub (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sub_i (op_i[1]),
    .sum_o (arith_y),
    .ovf_o (arith_ovf)
  );

  always_comb begin
    result_o = '0;
    if (is_logic)      result_o = logic_y;
    else if (is_shift) result_o = shift_y;
    else if (is_arith) result_o = arith_y;
  end

  assign ovf_exc_o = trap_en & arith_ovf;
  assign wr_en_o   = (is_logic | is_shift | is_arith) & ~ovf_exc_o;
endmodule

// File: rtl/alu_lsa_chk.sv
module alu_lsa_chk #(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input logic [W-1:0]  opa_i,
  input logic [W-1:0]  opb_i,
  input logic [SW-1:0] shamt_i,
  input logic [3:0]    op_i,
  input logic [W-1:0]  result_o,
  input logic          wr_en_o,
  input logic          ovf_exc_o
);
  logic signed [W:0] s_add, s_sub;
  logic              add_oor, sub_oor;

  always_comb begin
    s_add   = $signed({opa_i[W-1], opa_i}) + $signed({opb_i[W-1], opb_i});
    s_sub   = $signed({opa_i[W-1], opa_i}) - $signed({opb_i[W-1], opb_i});
    add_oor = s_add[W] != s_add[W-1];
    sub_oor = s_sub[W] != s_sub[W-1];

    // R11
    wr_suppress_chk: assert (!(ovf_exc_o && wr_en_o))
      else $error("write enabled during exception");
    // R8
    add_trap_chk: assert (op_i != 4'd8 || ovf_exc_o == add_oor)
      else $error("add trap mismatch");
    // R9
    sub_trap_chk: assert (op_i != 4'd10 || ovf_exc_o == sub_oor)
      else $error("sub trap mismatch");
    // R10
    no_overflow_chk: assert (op_i == 4'd8 || op_i == 4'd10 || !ovf_exc_o)
      else $error("exception from non-trapping code");
    // R6
    shift_zero_chk: assert (!(op_i inside {4'd4, 4'd5, 4'd6}) || shamt_i != '0
                            || result_o == opa_i)
      else $error("zero shift altered operand");
    // R5
    sra_sign_chk: assert (op_i != 4'd6 || result_o[W-1] == opa_i[W-1])
      else $error("arith shift lost sign");
    // R12
    undef_op_chk: assert (!(op_i == 4'd7 || op_i >= 4'd12)
                          || (result_o == '0 && !wr_en_o && !ovf_exc_o))
      else $error("undefined code produced output");
  end
endmodule

bind alu_lsa alu_lsa_chk #(.W(W)) u_chk (.*);

// File: tb/alu_lsa_tb.sv
module alu_lsa_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] opa, opb, res;
  logic [4:0]  shamt;
  logic [3:0]  op;
  logic        wr_en, ovf;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alu_lsa u_dut (
    .opa_i     (opa),
    .opb_i     (opb),
    .shamt_i   (shamt),
    .op_i      (op),
    .result_o  (res),
    .wr_en_o   (wr_en),
    .ovf_exc_o (ovf)
  );

  function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [4:0] s, input logic [3:0] c);
    logic [31:0] r;
    logic        x;
    logic        we;
    longint      sa, sb, sr;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = '0; x = 1'b0; we = 1'b1;
    case (c)
      4'd0: r = a & b;
      4'd1: r = a | b;
      4'd2: r = a ^ b;
      4'd3: r = ~(a | b);
      4'd4: r = a << s;
      4'd5: r = a >> s;
      4'd6: r = $unsigned($signed(a) >>> s);
      4'd8, 4'd9: begin
        sr = sa + sb; r = a + b;
        x = (c == 4'd8) && (sr > 64'sd2147483647 || sr < -64'sd2147483648);
      end
      4'd10, 4'd11: begin
        sr = sa - sb; r = a - b;
        x = (c == 4'd10) && (sr > 64'sd2147483647 || sr < -64'sd2147483648);
      end
      default: we = 1'b0;
    endcase
    if (x) we = 1'b0;
    return {we, x, r};
  endfunction

  function automatic string req_of(input logic [3:0] c, input logic [4:0] s);
    if (c <= 4'd2) return "R1";
    if (c == 4'd3) return "R2";
    if (c inside {4'd4, 4'd5, 4'd6} && s == 0) return "R6";
    if (c == 4'd4) return "R3";
    if (c == 4'd5) return "R4";
    if (c == 4'd6) return "R5";
    if (c == 4'd8) return "R8";
    if (c == 4'd10) return "R9";
    if (c == 4'd9 || c == 4'd11) return "R10";
    return "R12";
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] s, input logic [3:0] c, input string tag);
    logic [33:0] exp;
    @(negedge clk);
    opa = a; opb = b; shamt = s; op = c;
    #5;
    exp = model(a, b, s, c);
    n_run++;
    if (res !== exp[31:0] || ovf !== exp[32] || wr_en !== exp[33]) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h s=%0d: got res=%h ovf=%b we=%b exp res=%h ovf=%b we=%b",
               tag, c, a, b, s, res, ovf, wr_en, exp[31:0], exp[32], exp[33]);
    end
  endtask

  initial begin
    opa = '0; opb = '0; shamt = '0; op = 4'd0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state inputs: AND of zeros
    apply(32'h0, 32'h0, 5'd0, 4'd0, "R1");
    // R1 masking / merging
    apply(32'h0000_0DC0, 32'h0000_3C00, 5'd0, 4'd0, "R1");
    apply(32'h0000_0DC0, 32'h0000_3C00, 5'd0, 4'd1, "R1");
    apply(32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0, 4'd2, "R1");
    // R2 NOT via zero operand
    apply(32'h0000_3C00, 32'h0, 5'd0, 4'd3, "R2");
    // R3 R4 R5 extremes
    apply(32'hFFFF_FFFF, 32'h0, 5'd31, 4'd4, "R3");
    apply(32'h8000_0001, 32'h0, 5'd31, 4'd5, "R4");
    apply(32'h8000_0000, 32'h0, 5'd31, 4'd6, "R5");
    apply(32'h7FFF_FFFF, 32'h0, 5'd4, 4'd6, "R5");
    // R6 zero shift
    apply(32'h9ABC_DEF0, 32'h0, 5'd0, 4'd4, "R6");
    apply(32'h9ABC_DEF0, 32'h0, 5'd0, 4'd5, "R6");
    apply(32'h9ABC_DEF0, 32'h0, 5'd0, 4'd6, "R6");
    // R7 R8 R11 trapping add boundaries
    apply(32'h7FFF_FFFF, 32'h1, 5'd0, 4'd8, "R8");
    apply(32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 4'd8, "R8");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 5'd0, 4'd8, "R8");
    apply(32'h7FFF_FFFE, 32'h1, 5'd0, 4'd8, "R7");
    // R9 trapping sub boundaries
    apply(32'h8000_0000, 32'h1, 5'd0, 4'd10, "R9");
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 4'd10, "R9");
    apply(32'h8000_0000, 32'h8000_0000, 5'd0, 4'd10, "R9");
    apply(32'h0000_0007, 32'h0000_0006, 5'd0, 4'd10, "R7");
    // R10 wrapping flavours
    apply(32'h7FFF_FFFF, 32'h1, 5'd0, 4'd9, "R10");
    apply(32'h8000_0000, 32'h1, 5'd0, 4'd11, "R10");
    // R12 undefined codes
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 4'd7, "R12");
    for (int c = 12; c < 16; c++)
      apply(32'h8000_0000, 32'h8000_0000, 5'd1, 4'(c), "R12");
    // random, sign bits steered toward overflow regions
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      logic [3:0]  c;
      a = $urandom; b = $urandom;
      c = 4'($urandom_range(0, 15));
      if (i % 3 == 0) begin
        a[31:28] = {a[31], {3{~a[31]}}};
        b[31:28] = {b[31], {3{~b[31]}}};
      end
      apply(a, b, 5'($urandom), c, req_of(c, 5'd1));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule